// File: doc/BRIEF.md
# SDR SDRAM Controller

This block sits between a single on-chip requester and one rank of a 64-bit single-data-rate SDRAM module. That module is built from four-bank devices, each with 12 row bits and 9 column bits. The requester holds a request (address, read or write flag, write data and byte enables) until the block acknowledges it. Read data comes back later with a one-cycle valid strobe. On the memory side the block drives clock enable, the four command strobes, bank and address lines, and the byte masks. For the bidirectional data bus it provides an output word, an output enable and an input word, so the pad buffer can sit outside the block.

After reset the block runs its start-up sequence and then serves requests one at a time with single-beat accesses. The sequence is a long idle wait, a precharge of all banks, two refreshes and a mode-register write. The block keeps one row open between requests. A refresh timer raises a pending refresh at a fixed interval. That refresh is served ahead of new requests, and any open row is closed first. Every gap between commands is held to a clock count. The counts are chosen by the CAS latency parameter (2 or 3).

Top module: `sdram_ctrl`

## Requirements
- R1: While reset is low, clock enable is low, the command pins {CS#,RAS#,CAS#,WE#} show no-operation (0111), and both `rdValid` and `reqAck` are low.
- R2: After reset, clock enable rises and only no-operations are issued for at least INIT_WAIT cycles. The first four other commands are then, in order: a precharge with A10 high, an auto refresh, another auto refresh, and a mode-register write. No activate, read or write comes before the mode-register write.
- R3: The mode-register write carries BA=00 and an address word with A2:A0=000 (burst of one), A3=0 (sequential), A6:A4 equal to the CAS latency, and all other bits 0.
- R4: Commands are coded on {CS#,RAS#,CAS#,WE#} as: no-op 0111, activate 0011, read 0101, write 0100, precharge 0010, auto refresh 0001, mode write 0000. No other code is issued after reset.
- R5: A read or write comes at least tRCD cycles after the activate that opened its row. Two activates are at least tRC cycles apart. With CAS latency 2, tRCD is 2 and tRC is 7; with latency 3, tRCD is 3 and tRC is 9.
- R6: A precharge comes at least tRAS cycles after the last activate (5 at latency 2, 6 at latency 3) and at least WR_CLKS cycles after the last write. An activate or refresh comes at least tRP cycles after a precharge (2 at latency 2, 3 at latency 3).
- R7: No command follows a mode-register write for T_MRD cycles. No command follows an auto refresh for T_RFC cycles.
- R8: The request address maps as follows: bits 8:0 are the column, on A8:A0 of the read or write; bits 10:9 are the bank, on BA; bits 22:11 are the row, on A11:A0 of the activate. Reads and writes carry A10=0.
- R9: A request to the open row issues its column command with no new activate. A request to a different row precharges that bank (A10=0) and then activates the new row.
- R10: After initialisation, auto refreshes occur every REF_INTERVAL cycles, give or take 20 cycles, whether or not requests keep arriving. A refresh is issued only when no row is open.
- R11: A write puts the write data on the data output, with output enable high and DQM equal to the inverted byte enables, in the same cycle as the write command. Bytes with enable 0 keep their old contents. Output enable is low in every other cycle.
- R12: DQM is low CAS-latency minus 2 cycles after a read command. `rdValid` pulses for one cycle, CAS latency plus 1 cycles after the read command is on the pins, and `rdData` then holds that location's data.
- R13: `reqAck` is high for exactly one cycle per request: the cycle before that request's read or write command appears on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present; held until acknowledged |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 23 | {row, bank, column} |
| reqWdata | input | 64 | Write data |
| reqBe | input | 8 | Write byte enables |
| reqAck | output | 1 | Request taken this cycle |
| rdData | output | 64 | Read data |
| rdValid | output | 1 | Read data valid strobe |
| sdCke | output | 1 | Clock enable |
| sdCsN | output | 1 | Chip select, active low |
| sdRasN | output | 1 | Row strobe, active low |
| sdCasN | output | 1 | Column strobe, active low |
| sdWeN | output | 1 | Write enable, active low |
| sdBa | output | 2 | Bank address |
| sdAddr | output | 12 | Row/column/mode address |
| sdDqm | output | 8 | Byte masks |
| sdDqOut | output | 64 | Data toward memory |
| sdDqOe | output | 1 | Data output enable for the pad buffer |
| sdDqIn | input | 64 | Data from memory |

## Verification
A timing counter that is wrong shows up in the command stream at once. A column command, precharge or activate then lands closer to its predecessor than the clock count allows, and a protocol-checking memory model sees it on that very command. A stale open-row record shows up at the data side a few cycles later. The controller then reads or writes the wrong row without a fresh activate, and the scoreboard finds wrong read data when that location is read back. A broken refresh timer shows up within one refresh interval as a missing or early refresh. A wrong read shift length shows up as a valid strobe one cycle off, which pops mismatched data in the scoreboard.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;
  localparam int ROW_W  = 12;
  localparam int COL_W  = 9;
  localparam int BANK_W = 2;
  localparam int DATA_W = 64;
  localparam int BE_W   = DATA_W / 8;
  localparam int ADDR_W = ROW_W + BANK_W + COL_W;

  // {CS#, RAS#, CAS#, WE#}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdCmd_e;

  typedef struct packed {
    sdCmd_e            cmd;
    logic [BANK_W-1:0] ba;
    logic [ROW_W-1:0]  addr;
    logic              isRead;
    logic              isWrite;
  } ctrlStrobe_t;
endpackage

// File: rtl/sdram_ctrl_fsm.sv
module sdram_ctrl_fsm
  import sdram_ctrl_pkg::*;
#(
  parameter int CAS_LAT      = 2,
  parameter int INIT_WAIT    = 10000,
  parameter int REF_INTERVAL = 1560,
  parameter int T_RCD        = 2,
  parameter int T_RP         = 2,
  parameter int T_RAS        = 5,
  parameter int T_RC         = 7,
  parameter int T_RFC        = 7,
  parameter int T_MRD        = 2,
  parameter int WR_CLKS      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output ctrlStrobe_t       strobe,
  output logic              reqAck
);
  localparam int MAX_GAP = (INIT_WAIT > 64) ? INIT_WAIT : 64;
  localparam int GAP_W   = $clog2(MAX_GAP + 1);
  localparam int REF_W   = $clog2(REF_INTERVAL + 1);
  localparam int TC_W    = 5;

  typedef enum logic [3:0] {
    ST_PWR, ST_IREF, ST_IMRS, ST_IDLE, ST_PRE, ST_REF, ST_ACT, ST_RW
  } state_e;

  state_e            state, stateNext;
  logic [GAP_W-1:0]  gapCnt;
  logic [TC_W-1:0]   rasCnt, rcCnt, wrCnt;
  logic [REF_W-1:0]  refCnt;
  logic              refDue, refEn, secondRef;
  logic              rowOpen;
  logic [BANK_W-1:0] openBank;
  logic [ROW_W-1:0]  openRow;

  logic [COL_W-1:0]  reqCol;
  logic [BANK_W-1:0] reqBank;
  logic [ROW_W-1:0]  reqRow;
  logic              gapZero, rowHit;
  logic [ROW_W-1:0]  modeWord;

  assign reqCol   = reqAddr[COL_W-1:0];
  assign reqBank  = reqAddr[COL_W +: BANK_W];
  assign reqRow   = reqAddr[COL_W+BANK_W +: ROW_W];
  assign gapZero  = (gapCnt == '0);
  assign rowHit   = rowOpen && (openBank == reqBank) && (openRow == reqRow);
  assign modeWord = ROW_W'({3'(CAS_LAT), 1'b0, 3'b000});

  always_comb begin
    strobe    = '{cmd: CMD_NOP, ba: '0, addr: '0, isRead: 1'b0, isWrite: 1'b0};
    stateNext = state;
    case (state)
      ST_PWR: if (gapZero) begin
        strobe.cmd      = CMD_PRE;
        strobe.addr[10] = 1'b1;
        stateNext       = ST_IREF;
      end
      ST_IREF: if (gapZero) begin
        strobe.cmd = CMD_REF;
        if (secondRef) stateNext = ST_IMRS;
      end
      ST_IMRS: if (gapZero) begin
        strobe.cmd  = CMD_MRS;
        strobe.addr = modeWord;
        stateNext   = ST_IDLE;
      end
      ST_IDLE: begin
        if (refDue)        stateNext = rowOpen ? ST_PRE : ST_REF;
        else if (reqValid) stateNext = rowHit ? ST_RW : (rowOpen ? ST_PRE : ST_ACT);
      end
      ST_PRE: if (gapZero && rasCnt == '0 && wrCnt == '0) begin
        strobe.cmd = CMD_PRE;
        strobe.ba  = openBank;
        stateNext  = ST_IDLE;
      end
      ST_REF: if (gapZero) begin
        strobe.cmd = CMD_REF;
        stateNext  = ST_IDLE;
      end
      ST_ACT: if (gapZero && rcCnt == '0) begin
        strobe.cmd  = CMD_ACT;
        strobe.ba   = reqBank;
        strobe.addr = reqRow;
        stateNext   = ST_RW;
      end
      ST_RW: if (gapZero) begin
        strobe.cmd     = reqWrite ? CMD_WR : CMD_RD;
        strobe.ba      = reqBank;
        strobe.addr    = ROW_W'(reqCol);
        strobe.isRead  = !reqWrite;
        strobe.isWrite = reqWrite;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqAck = strobe.isRead | strobe.isWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_PWR;
      gapCnt    <= GAP_W'(INIT_WAIT);
      rasCnt    <= '0;
      rcCnt     <= '0;
      wrCnt     <= '0;
      refCnt    <= REF_W'(REF_INTERVAL - 1);
      refDue    <= 1'b0;
      refEn     <= 1'b0;
      secondRef <= 1'b0;
      rowOpen   <= 1'b0;
      openBank  <= '0;
      openRow   <= '0;
    end else begin
      state <= stateNext;
      case (strobe.cmd)
        CMD_PRE: gapCnt <= GAP_W'(T_RP - 1);
        CMD_REF: gapCnt <= GAP_W'(T_RFC - 1);
        CMD_MRS: gapCnt <= GAP_W'(T_MRD - 1);
        CMD_ACT: gapCnt <= GAP_W'(T_RCD - 1);
        CMD_RD, CMD_WR: gapCnt <= '0;
        default: if (!gapZero) gapCnt <= gapCnt - 1'b1;
      endcase
      if (strobe.cmd == CMD_ACT) begin
        rasCnt   <= TC_W'(T_RAS - 1);
        rcCnt    <= TC_W'(T_RC - 1);
        rowOpen  <= 1'b1;
        openBank <= strobe.ba;
        openRow  <= strobe.addr;
      end else begin
        if (rasCnt != '0) rasCnt <= rasCnt - 1'b1;
        if (rcCnt != '0)  rcCnt  <= rcCnt - 1'b1;
      end
      if (strobe.cmd == CMD_PRE) rowOpen <= 1'b0;
      if (strobe.cmd == CMD_WR)  wrCnt <= TC_W'(WR_CLKS - 1);
      else if (wrCnt != '0)      wrCnt <= wrCnt - 1'b1;
      if (state == ST_IREF && strobe.cmd == CMD_REF) secondRef <= 1'b1;
      if (strobe.cmd == CMD_MRS) refEn <= 1'b1;
      if (refEn && strobe.cmd == CMD_REF) refDue <= 1'b0;
      if (refEn) begin
        if (refCnt == '0) begin
          refCnt <= REF_W'(REF_INTERVAL - 1);
          refDue <= 1'b1;
        end else begin
          refCnt <= refCnt - 1'b1;
        end
      end
    end
  end

  // R10: refresh only with every row closed
  p_ref_closed_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cmd == CMD_REF) |-> !rowOpen);
  // R7: the cycle after a mode write carries no command
  p_mrd_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cmd == CMD_MRS) |=> (strobe.cmd == CMD_NOP));
  // R13: acknowledge is a single-cycle pulse
  p_ack_pulse_r13: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);
endmodule

// File: rtl/sdram_ctrl_dp.sv
module sdram_ctrl_dp
  import sdram_ctrl_pkg::*;
#(
  parameter int CAS_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [BE_W-1:0]   reqBe,
  input  logic [DATA_W-1:0] sdDqIn,
  output logic              sdCke,
  output logic [3:0]        sdCmd,
  output logic [BANK_W-1:0] sdBa,
  output logic [ROW_W-1:0]  sdAddr,
  output logic [BE_W-1:0]   sdDqm,
  output logic [DATA_W-1:0] sdDqOut,
  output logic              sdDqOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);
  sdCmd_e             cmdQ;
  logic [CAS_LAT-1:0] rdPipe;
  logic               pinRead, readMaskOpen;

  assign sdCmd   = cmdQ;
  assign pinRead = (cmdQ == CMD_RD);
  // read mask is sampled CAS_LAT-2 cycles after the read command
  assign readMaskOpen = (CAS_LAT == 2) ? strobe.isRead : pinRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ    <= CMD_NOP;
      sdCke   <= 1'b0;
      sdBa    <= '0;
      sdAddr  <= '0;
      sdDqm   <= '1;
      sdDqOut <= '0;
      sdDqOe  <= 1'b0;
      rdPipe  <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      sdCke  <= 1'b1;
      cmdQ   <= strobe.cmd;
      sdBa   <= strobe.ba;
      sdAddr <= strobe.addr;
      sdDqOe <= strobe.isWrite;
      if (strobe.isWrite) sdDqOut <= reqWdata;
      sdDqm  <= strobe.isWrite ? ~reqBe : (readMaskOpen ? '0 : '1);
      rdPipe <= {rdPipe[CAS_LAT-2:0], pinRead};
      rdValid <= rdPipe[CAS_LAT-1];
      if (rdPipe[CAS_LAT-1]) rdData <= sdDqIn;
    end
  end

  // R12: valid strobe trails the read command by CAS_LAT+1 cycles
  p_rd_latency_r12: assert property (@(posedge clk) disable iff (!rstN)
    rdValid == $past(pinRead, CAS_LAT + 1));
  // R11: write data and masks come out with the write command
  p_write_drive_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_WR) |-> (sdDqOe && sdDqm == ~$past(reqBe)));
endmodule

// File: rtl/sdram_ctrl.sv
module sdram_ctrl
  import sdram_ctrl_pkg::*;
#(
  parameter int CAS_LAT      = 2,
  parameter int INIT_WAIT    = 10000,
  parameter int REF_INTERVAL = 1560,
  parameter int T_RFC        = 7,
  parameter int T_MRD        = 2,
  parameter int WR_CLKS      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [BE_W-1:0]   reqBe,
  output logic              reqAck,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [BANK_W-1:0] sdBa,
  output logic [ROW_W-1:0]  sdAddr,
  output logic [BE_W-1:0]   sdDqm,
  output logic [DATA_W-1:0] sdDqOut,
  output logic              sdDqOe,
  input  logic [DATA_W-1:0] sdDqIn
);
  localparam int T_RCD = (CAS_LAT == 2) ? 2 : 3;
  localparam int T_RP  = (CAS_LAT == 2) ? 2 : 3;
  localparam int T_RAS = (CAS_LAT == 2) ? 5 : 6;
  localparam int T_RC  = (CAS_LAT == 2) ? 7 : 9;

  ctrlStrobe_t strobe;
  logic [3:0]  pinCmd;

  sdram_ctrl_fsm #(
    .CAS_LAT(CAS_LAT), .INIT_WAIT(INIT_WAIT), .REF_INTERVAL(REF_INTERVAL),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC),
    .T_RFC(T_RFC), .T_MRD(T_MRD), .WR_CLKS(WR_CLKS)
  ) fsm_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .strobe(strobe), .reqAck(reqAck)
  );

  sdram_ctrl_dp #(.CAS_LAT(CAS_LAT)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWdata(reqWdata), .reqBe(reqBe),
    .sdDqIn(sdDqIn), .sdCke(sdCke), .sdCmd(pinCmd), .sdBa(sdBa), .sdAddr(sdAddr),
    .sdDqm(sdDqm), .sdDqOut(sdDqOut), .sdDqOe(sdDqOe), .rdData(rdData), .rdValid(rdValid)
  );

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = pinCmd;

  // R5: no column command within tRCD of an activate on the pins
  p_rcd_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pinCmd == 4'(CMD_RD) || pinCmd == 4'(CMD_WR)) |->
      ($past(pinCmd) != 4'(CMD_ACT)) && ((T_RCD < 3) || ($past(pinCmd, 2) != 4'(CMD_ACT))));
endmodule

// File: tb/sdram_ctrl_tb_top.sv
module sdram_ctrl_tb_top;
  localparam int CL    = 3;
  localparam int INIT  = 40;
  localparam int REFI  = 300;
  localparam int TRFC  = 7;
  localparam int TMRD  = 2;
  localparam int TWR   = 2;
  localparam int E_RCD = 3, E_RP = 3, E_RAS = 6, E_RC = 9;
  localparam logic [11:0] E_MODE = 12'h030;
  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
    C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, reqValid, reqWrite, reqAck, rdValid;
  logic [22:0] reqAddr;
  logic [63:0] reqWdata, rdData, sdDqOut, sdDqIn;
  logic [7:0]  reqBe, sdDqm;
  logic        sdCke, sdCsN, sdRasN, sdCasN, sdWeN, sdDqOe;
  logic [1:0]  sdBa;
  logic [11:0] sdAddr;

  sdram_ctrl #(.CAS_LAT(CL), .INIT_WAIT(INIT), .REF_INTERVAL(REFI), .T_RFC(TRFC),
    .T_MRD(TMRD), .WR_CLKS(TWR)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqBe(reqBe), .reqAck(reqAck), .rdData(rdData), .rdValid(rdValid),
    .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdBa(sdBa), .sdAddr(sdAddr), .sdDqm(sdDqm), .sdDqOut(sdDqOut), .sdDqOe(sdDqOe),
    .sdDqIn(sdDqIn));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- memory model with protocol checks ----------------
  int ncyc = 0, firstCke = -1, initIdx = 0;
  int lastAct = -1000, lastPre = -1000, lastRef = -1000, lastMrs = -1000, lastWr = -1000;
  int lastPostRef = -1, ackNeg = -10, acts = 0, pres = 0, refs = 0;
  bit bankOpen [4];
  logic [11:0] bankRow [4];
  logic [63:0] mem [int];
  int rdDue [$];
  logic [63:0] rdVal [$];
  int dqmDue [$];

  always @(negedge clk) begin
    logic [3:0] cmd;
    int key;
    ncyc++;
    cmd = {sdCsN, sdRasN, sdCasN, sdWeN};
    if (rstN) begin
      if (sdCke && firstCke < 0) firstCke = ncyc;
      if (sdDqOe && cmd != C_WR) chk(0, "R11 output enable outside write", 1, 0);
      if (cmd != C_NOP) begin
        chk(ncyc - lastMrs >= TMRD, "R7 tMRD", ncyc - lastMrs, TMRD);
        chk(ncyc - lastRef >= TRFC, "R7 tRFC", ncyc - lastRef, TRFC);
        if (initIdx < 4) begin
          case (initIdx)
            0: begin
              chk(cmd == C_PRE && sdAddr[10], "R2 first command precharge-all", cmd, C_PRE);
              chk(firstCke >= 0 && ncyc - firstCke >= INIT, "R2 init wait", ncyc - firstCke, INIT);
            end
            1, 2: chk(cmd == C_REF, "R2 init refresh", cmd, C_REF);
            default: chk(cmd == C_MRS, "R2 mode write last", cmd, C_MRS);
          endcase
          initIdx++;
        end
      end
      case (cmd)
        C_NOP: ;
        C_PRE: begin
          chk(ncyc - lastAct >= E_RAS, "R6 tRAS", ncyc - lastAct, E_RAS);
          chk(ncyc - lastWr >= TWR, "R6 write recovery", ncyc - lastWr, TWR);
          if (sdAddr[10]) for (int b = 0; b < 4; b++) bankOpen[b] = 0;
          else bankOpen[sdBa] = 0;
          lastPre = ncyc; pres++;
        end
        C_REF: begin
          chk(!(bankOpen[0] | bankOpen[1] | bankOpen[2] | bankOpen[3]), "R10 refresh with row open", 1, 0);
          chk(ncyc - lastPre >= E_RP, "R6 tRP before refresh", ncyc - lastPre, E_RP);
          if (initIdx > 4 || (initIdx == 4 && lastPostRef >= 0)) begin
            chk(ncyc - lastPostRef <= REFI + 20 && ncyc - lastPostRef >= REFI - 20,
                "R10 refresh interval", ncyc - lastPostRef, REFI);
            lastPostRef = ncyc; refs++;
          end
          lastRef = ncyc;
        end
        C_MRS: begin
          chk(sdAddr == E_MODE && sdBa == 2'b00, "R3 mode word", {sdBa, sdAddr}, E_MODE);
          lastMrs = ncyc; lastPostRef = ncyc;
        end
        C_ACT: begin
          chk(initIdx == 4 && !bankOpen[sdBa], "R2 activate ordering", bankOpen[sdBa], 0);
          chk(ncyc - lastPre >= E_RP, "R6 tRP before activate", ncyc - lastPre, E_RP);
          chk(ncyc - lastAct >= E_RC, "R5 tRC", ncyc - lastAct, E_RC);
          bankOpen[sdBa] = 1; bankRow[sdBa] = sdAddr;
          lastAct = ncyc; acts++;
        end
        C_RD, C_WR: begin
          chk(initIdx == 4 && bankOpen[sdBa], "R9 column command to open row", bankOpen[sdBa], 1);
          chk(ncyc - lastAct >= E_RCD, "R5 tRCD", ncyc - lastAct, E_RCD);
          chk(!sdAddr[10], "R8 no auto-precharge", sdAddr[10], 0);
          chk(ackNeg == ncyc - 1, "R13 ack one cycle before column command", ackNeg, ncyc - 1);
          key = int'({bankRow[sdBa], sdBa, sdAddr[8:0]});
          if (cmd == C_WR) begin
            logic [63:0] old;
            chk(sdDqOe, "R11 output enable on write", sdDqOe, 1);
            old = mem.exists(key) ? mem[key] : 64'h0;
            for (int b = 0; b < 8; b++) if (!sdDqm[b]) old[b*8 +: 8] = sdDqOut[b*8 +: 8];
            mem[key] = old;
            lastWr = ncyc;
          end else begin
            rdDue.push_back(ncyc + CL);
            rdVal.push_back(mem.exists(key) ? mem[key] : 64'h0);
            dqmDue.push_back(ncyc + CL - 2);
          end
        end
        default: chk(0, "R4 illegal command code", cmd, C_NOP);
      endcase
      if (dqmDue.size() > 0 && dqmDue[0] == ncyc) begin
        void'(dqmDue.pop_front());
        chk(sdDqm == 8'h00, "R12 read mask low", sdDqm, 0);
      end
      if (rdDue.size() > 0 && rdDue[0] == ncyc) begin
        void'(rdDue.pop_front());
        sdDqIn = rdVal.pop_front();
      end
      if (reqAck) ackNeg = ncyc;
    end
  end

  // ---------------- scoreboard ----------------
  logic [63:0] shadow [int];
  logic [63:0] expQ [$];
  int rdSeen = 0, rdIssued = 0;

  always @(negedge clk) begin
    if (rstN && rdValid) begin
      rdSeen++;
      if (expQ.size() == 0) chk(0, "R12 unexpected read valid", 1, 0);
      else begin
        logic [63:0] e;
        e = expQ.pop_front();
        chk(rdData == e, "R12 read data", rdData, e);
      end
    end
  end

  function automatic logic [22:0] mkAddr(input int row, input int bank, input int col);
    return {row[11:0], bank[1:0], col[8:0]};
  endfunction

  task automatic issue(input bit wr, input logic [22:0] a, input logic [63:0] d, input logic [7:0] be);
    @(posedge clk); #1;
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be;
    do @(negedge clk); while (!reqAck);
    @(posedge clk); #1;
    reqValid = 0;
  endtask

  task automatic doWrite(input logic [22:0] a, input logic [63:0] d, input logic [7:0] be);
    logic [63:0] old;
    old = shadow.exists(int'(a)) ? shadow[int'(a)] : 64'h0;
    for (int b = 0; b < 8; b++) if (be[b]) old[b*8 +: 8] = d[b*8 +: 8];
    shadow[int'(a)] = old;
    issue(1, a, d, be);
  endtask

  task automatic doRead(input logic [22:0] a);
    expQ.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 64'h0);
    rdIssued++;
    issue(0, a, 64'h0, 8'h00);
  endtask

  task automatic runAll();
    int a0, r0, p0;
    rstN = 0; reqValid = 0; reqWrite = 0; reqAddr = '0; reqWdata = '0; reqBe = '0; sdDqIn = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!sdCke, "R1 clock enable low in reset", sdCke, 0);
      chk({sdCsN, sdRasN, sdCasN, sdWeN} == C_NOP, "R1 no-op in reset", {sdCsN, sdRasN, sdCasN, sdWeN}, C_NOP);
      chk(!rdValid && !reqAck, "R1 strobes low in reset", {rdValid, reqAck}, 0);
    end
    @(posedge clk); #1 rstN = 1;
    while (initIdx < 4) @(negedge clk);
    chk(1, "R2 init sequence complete", 1, 1);

    // same-row accesses: one activate at most (plus refresh reopen)
    a0 = acts; r0 = refs;
    for (int c = 0; c < 8; c++) doWrite(mkAddr(5, 1, c * 3), {32'hC0DE0000 + c, 32'h1234_5678 ^ c}, 8'hFF);
    for (int c = 0; c < 8; c++) doRead(mkAddr(5, 1, c * 3));
    chk(acts - a0 <= 1 + (refs - r0), "R9 row hit avoids activate", acts - a0, 1);

    // partial write keeps disabled bytes
    doWrite(mkAddr(5, 1, 3), 64'hFFEE_DDCC_BBAA_9988, 8'h0F);
    doRead(mkAddr(5, 1, 3));

    // row miss in the same bank: precharge then activate
    a0 = acts; p0 = pres;
    doWrite(mkAddr(9, 1, 0), 64'h0BAD_F00D_0000_0009, 8'hFF);
    chk(acts - a0 == 1 && pres - p0 >= 1, "R9 row miss reopens", acts - a0, 1);
    doRead(mkAddr(9, 1, 0));
    doRead(mkAddr(5, 1, 6));

    // mixed traffic across banks, rows and columns (R8 mapping)
    for (int i = 0; i < 40; i++) begin
      logic [22:0] a;
      a = mkAddr((i * 7) % 4096, i % 4, (i * 37) % 512);
      doWrite(a, {9'(i), a, 32'hA5A50000 | i}, (i % 5 == 0) ? 8'hF0 : 8'hFF);
      if (i % 3 == 0) doRead(mkAddr(((i - 3 + 4096) * 7) % 4096, (i + 1) % 4, 511));
      doRead(a);
    end
    for (int i = 0; i < 40; i += 4) doRead(mkAddr((i * 7) % 4096, i % 4, (i * 37) % 512));

    // idle: refreshes keep coming
    r0 = refs;
    repeat (3 * REFI) @(posedge clk);
    chk(refs - r0 >= 2, "R10 refreshes while idle", refs - r0, 3);

    repeat (20) @(posedge clk);
    chk(expQ.size() == 0 && rdSeen == rdIssued, "R12 all reads returned", rdSeen, rdIssued);
  endtask

  initial begin
    bit timedOut;
    timedOut = 0;
    fork
      runAll();
      begin repeat (150000) @(posedge clk); timedOut = 1; end
    join_any
    disable fork;
    if (timedOut) chk(0, "watchdog expired (R13 handshake)", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule